// File: doc/BRIEF.md
# Deep Sleep Watchdog Timer

This block is a watchdog that counts only while the device is in deep sleep. When it expires, it raises a single wake event. Its own configuration bit enables it, with no dependence on any main watchdog. A select bit chooses between two slow clock sources: an RC oscillator or a crystal oscillator. A four-bit postscale code sets the timeout to one of sixteen power-of-two periods.

On each entry into deep sleep the count restarts from zero. If the chosen source has not been switched on by software, the block requests it on its own for as long as deep sleep lasts. The source's ready flag reaches the counter through a two-stage synchroniser. Counting therefore starts only once the source is running and that flag has crossed, so a cold source delays the start.

The block runs in the slow counting clock domain, `clk`. Leaving deep sleep freezes the count. After one timeout pulse the block stays silent until the next deep-sleep entry.

Top module: `dsleep_wdt`

## Requirements
- R1: After a synchronous active-low reset, `wake_pulse` is 0, the count is zero, and the ready synchronisers hold 0.
- R2: With `cfg_enable` = 0, `wake_pulse` stays 0 and neither request is raised by the block. Each request then equals its software enable.
- R3: Every rising edge of `deep_sleep` clears the count and re-arms the block, so a full period elapses again after re-entry.
- R4: `cfg_src` = 0 selects the RC source and `cfg_src` = 1 selects the crystal. Only the selected source's synchronised ready flag gates counting. The other ready flag is ignored.
- R5: For code c in `cfg_ps`, `wake_pulse` goes high in the cycle after the N-th counting edge, where N = 2^(BASE_LOG2+c). Code 0 is the shortest period and code 15 the longest. The entry edge itself is not a counting edge.
- R6: `wake_pulse` is high for exactly one cycle. After it, the count holds and no further pulse occurs until the next deep-sleep entry.
- R7: While `deep_sleep` = 1 and `cfg_enable` = 1, the selected source's request output is 1 whatever its software enable. In every other case each request output equals its software enable.
- R8: The selected ready flag passes through two flops before it can enable counting. The count does not advance and no pulse is raised while `deep_sleep` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Watchdog enable configuration bit |
| cfg_src | input | 1 | Clock source select: 0 RC, 1 crystal |
| cfg_ps | input | 4 | Postscale code, period 2^(BASE_LOG2+code) |
| deep_sleep | input | 1 | Device is in deep sleep |
| sw_rc_on | input | 1 | Software enable of the RC source |
| sw_xtal_on | input | 1 | Software enable of the crystal source |
| rc_ready | input | 1 | RC source running (asynchronous) |
| xtal_ready | input | 1 | Crystal source running (asynchronous) |
| rc_req | output | 1 | Enable request to the RC source |
| xtal_req | output | 1 | Enable request to the crystal source |
| wake_pulse | output | 1 | One-cycle timeout wake event |

## Verification
Two of the block's functions can fall in the same cycle: a deep-sleep entry and a count that has just reached its terminal value. Entry must win and restart the period, so no stale pulse follows. The bench provokes this by leaving sleep partway through a period and re-entering, then checking the pulse count in a window that would have held a stale pulse had the count not been cleared. A second overlap is the automatic source request rising on the same edge as entry while that source's ready flag is still low. A behavioural reference model predicts the exact cycle of every pulse and every request level, and the bench compares the design against it on every clock.

// File: rtl/dsw_pkg.sv
// Shared types for the deep-sleep watchdog.
// Assumes: two clock sources, indexed by the select bit.
package dsw_pkg;
    typedef enum logic {
        SRC_RC   = 1'b0,
        SRC_XTAL = 1'b1
    } dsw_src_e;

    localparam int unsigned NUM_SRC = 2;
    localparam int unsigned PS_W    = 4;
endpackage

// File: rtl/dsw_sync.sv
// Two-flop synchroniser for one asynchronous level.
// Assumes: the input is a slow level, so one cycle of uncertainty is acceptable.
module dsw_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;

    // Purpose: move the level through two flops into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/dsw_clk_ctl.sv
// Clock source control: synchronises the ready flags, selects one, and
// raises the enable request for the chosen source during deep sleep.
// Assumes: requests may be combinational from configuration and sleep state.
module dsw_clk_ctl
    import dsw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  dsw_src_e src,
    input  logic     sleeping,
    input  logic     sw_rc_on,
    input  logic     sw_xtal_on,
    input  logic     rc_ready,
    input  logic     xtal_ready,
    output logic     rc_req,
    output logic     xtal_req,
    output logic     src_ready
);
    logic [NUM_SRC-1:0] raw_ready;
    logic [NUM_SRC-1:0] sync_ready;
    logic               auto_on;

    assign raw_ready = {xtal_ready, rc_ready};

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
            dsw_sync i_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .d_async (raw_ready[g]),
                .q_sync  (sync_ready[g])
            );
        end
    endgenerate

    // Purpose: force on the chosen source while armed in deep sleep.
    always_comb begin
        auto_on   = enable && sleeping;
        rc_req    = sw_rc_on   || (auto_on && (src == SRC_RC));
        xtal_req  = sw_xtal_on || (auto_on && (src == SRC_XTAL));
        src_ready = (src == SRC_XTAL) ? sync_ready[1] : sync_ready[0];
    end
endmodule

// File: rtl/dsw_counter.sv
// Timeout counter: cleared on deep-sleep entry, counts while armed and the
// source is ready, pulses once at terminal count and then holds.
// Assumes: code selects a period of 2^(BASE_LOG2+code) counting edges.
module dsw_counter #(
    parameter int unsigned BASE_LOG2 = 2,
    parameter int unsigned PS_W      = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            sleeping,
    input  logic            src_ready,
    input  logic [PS_W-1:0] code,
    output logic            pulse
);
    localparam int unsigned MAX_CODE = (1 << PS_W) - 1;
    localparam int unsigned CNT_W    = BASE_LOG2 + MAX_CODE;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] last_value;
    logic             sleep_q;
    logic             expired;
    logic             entry;
    logic             advance;
    logic             at_end;

    // Purpose: decode terminal value and counting condition.
    always_comb begin
        last_value = {CNT_W{1'b1}} >> (MAX_CODE[PS_W-1:0] - code);
        entry      = sleeping && !sleep_q;
        advance    = sleeping && sleep_q && enable && src_ready && !expired;
        at_end     = (count == last_value);
    end

    // Purpose: count, restart on entry, latch expiry and emit the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            sleep_q <= 1'b0;
            expired <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            sleep_q <= sleeping;
            pulse   <= advance && at_end;
            if (entry) begin
                count   <= '0;
                expired <= 1'b0;
            end else if (advance) begin
                if (at_end) begin
                    expired <= 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dsleep_wdt.sv
// Deep-sleep watchdog top: joins source control and the timeout counter.
// Assumes: clk is the slow counting clock; ready inputs are asynchronous.
module dsleep_wdt #(
    parameter int unsigned BASE_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       cfg_src,
    input  logic [3:0] cfg_ps,
    input  logic       deep_sleep,
    input  logic       sw_rc_on,
    input  logic       sw_xtal_on,
    input  logic       rc_ready,
    input  logic       xtal_ready,
    output logic       rc_req,
    output logic       xtal_req,
    output logic       wake_pulse
);
    import dsw_pkg::*;

    logic     sel_ready;
    dsw_src_e src_sel;

    assign src_sel = dsw_src_e'(cfg_src);

    dsw_clk_ctl i_clk_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .src        (src_sel),
        .sleeping   (deep_sleep),
        .sw_rc_on   (sw_rc_on),
        .sw_xtal_on (sw_xtal_on),
        .rc_ready   (rc_ready),
        .xtal_ready (xtal_ready),
        .rc_req     (rc_req),
        .xtal_req   (xtal_req),
        .src_ready  (sel_ready)
    );

    dsw_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .PS_W      (PS_W)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .sleeping  (deep_sleep),
        .src_ready (sel_ready),
        .code      (cfg_ps),
        .pulse     (wake_pulse)
    );
endmodule

// File: rtl/dsleep_wdt_chk.sv
// Port-level checker for the deep-sleep watchdog, bound to the top.
// Assumes: synchronous active-low reset; keeps its own fired flag.
module dsleep_wdt_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic cfg_src,
    input logic deep_sleep,
    input logic sw_rc_on,
    input logic sw_xtal_on,
    input logic rc_req,
    input logic xtal_req,
    input logic wake_pulse
);
    logic fired;
    logic ds_prev;

    // Purpose: remember whether a pulse occurred since the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired   <= 1'b0;
            ds_prev <= 1'b0;
        end else begin
            ds_prev <= deep_sleep;
            if (deep_sleep && !ds_prev) fired <= 1'b0;
            else if (wake_pulse)        fired <= 1'b1;
        end
    end

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_no_second_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> !fired);

    assert_pulse_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(cfg_enable));

    assert_pulse_only_in_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(deep_sleep));

    assert_auto_rc_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_sleep && cfg_enable && !cfg_src) |-> rc_req);

    assert_auto_xtal_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_sleep && cfg_enable && cfg_src) |-> xtal_req);

    assert_idle_requests_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(deep_sleep && cfg_enable) |-> (rc_req == sw_rc_on && xtal_req == sw_xtal_on));

    assert_entry_no_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_sleep && !ds_prev) |=> !wake_pulse);
endmodule

bind dsleep_wdt dsleep_wdt_chk i_dsleep_wdt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_src    (cfg_src),
    .deep_sleep (deep_sleep),
    .sw_rc_on   (sw_rc_on),
    .sw_xtal_on (sw_xtal_on),
    .rc_req     (rc_req),
    .xtal_req   (xtal_req),
    .wake_pulse (wake_pulse)
);

// File: tb/test_dsleep_wdt.sv
`timescale 1ns/100ps
module test_dsleep_wdt;
    localparam int B = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_src = 1'b0;
    logic [3:0] cfg_ps = 4'd0;
    logic       deep_sleep = 1'b0;
    logic       sw_rc_on = 1'b0;
    logic       sw_xtal_on = 1'b0;
    logic       rc_ready = 1'b0;
    logic       xtal_ready = 1'b0;
    logic       rc_req, xtal_req, wake_pulse;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    // Reference model state
    int m_cnt = 0;
    bit m_expired = 0, m_dsq = 0, m_pulse = 0;
    bit m_s1[2] = '{0, 0};
    bit m_s2[2] = '{0, 0};

    always #2.5 clk = ~clk;

    dsleep_wdt #(.BASE_LOG2(B)) i_dsleep_wdt (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src(cfg_src),
        .cfg_ps(cfg_ps), .deep_sleep(deep_sleep), .sw_rc_on(sw_rc_on),
        .sw_xtal_on(sw_xtal_on), .rc_ready(rc_ready), .xtal_ready(xtal_ready),
        .rc_req(rc_req), .xtal_req(xtal_req), .wake_pulse(wake_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model advanced on every edge, then compared mid-cycle.
    always @(posedge clk) begin
        int  period;
        bit  entry, rdy, cen;
        if (!rst_n) begin
            m_cnt = 0; m_expired = 0; m_dsq = 0; m_pulse = 0;
            m_s1 = '{0, 0}; m_s2 = '{0, 0};
        end else begin
            period = 1 << (B + cfg_ps);
            entry  = deep_sleep && !m_dsq;
            rdy    = cfg_src ? m_s2[1] : m_s2[0];
            cen    = deep_sleep && m_dsq && cfg_enable && rdy && !m_expired;
            m_pulse = cen && (m_cnt == period - 1);
            if (entry) begin
                m_cnt = 0; m_expired = 0;
            end else if (cen) begin
                if (m_cnt == period - 1) m_expired = 1;
                else m_cnt++;
            end
            m_s2 = m_s1;
            m_s1[0] = rc_ready; m_s1[1] = xtal_ready;
            m_dsq = deep_sleep;
        end
        #3;
        if (rst_n && !done) begin
            check("R5 wake_pulse timing", wake_pulse, m_pulse);
            check("R7 rc_req", rc_req, sw_rc_on | (deep_sleep & cfg_enable & !cfg_src));
            check("R7 xtal_req", xtal_req, sw_xtal_on | (deep_sleep & cfg_enable & cfg_src));
            if (wake_pulse) pulses++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int base;
        cycles(3);
        // R1: reset state
        check("R1 wake_pulse at reset", wake_pulse, 0);
        check("R1 requests at reset", {rc_req, xtal_req}, 0);
        rst_n = 1'b1;
        sw_rc_on = 1'b1; rc_ready = 1'b1; cfg_enable = 1'b1;
        cycles(10);
        // R8: awake, nothing counts
        check("R8 no pulse awake", pulses, 0);

        // R5/R6: code 0 -> 4 counting edges, one pulse only
        base = pulses; cfg_ps = 4'd0; deep_sleep = 1'b1;
        cycles(30);
        check("R5 one pulse code0", pulses - base, 1);
        check("R6 no repeat pulse", pulses - base, 1);

        // R3: partial period, leave, re-enter -> full 16 again (code 2)
        deep_sleep = 1'b0; cfg_ps = 4'd2; cycles(3);
        base = pulses; deep_sleep = 1'b1; cycles(10);
        deep_sleep = 1'b0; cycles(5);
        check("R8 no pulse after leaving", pulses - base, 0);
        deep_sleep = 1'b1; cycles(12);
        check("R3 count cleared on reentry", pulses - base, 0);
        cycles(10);
        check("R5 pulse code2 after full period", pulses - base, 1);

        // R4/R7/R8: crystal selected but off; request forced, start delayed
        deep_sleep = 1'b0; cfg_src = 1'b1; cfg_ps = 4'd0; cycles(3);
        base = pulses; deep_sleep = 1'b1; cycles(1);
        check("R7 crystal forced on", xtal_req, 1);
        rc_ready = 1'b0; cycles(4); rc_ready = 1'b1; cycles(15);
        check("R4 RC ready ignored while crystal selected", pulses - base, 0);
        xtal_ready = 1'b1; cycles(3);
        check("R8 ready still crossing", pulses - base, 0);
        cycles(10);
        check("R4 crystal counting pulse", pulses - base, 1);

        // R2: disabled -> no pulse, no forced request
        deep_sleep = 1'b0; cfg_src = 1'b0; cfg_enable = 1'b0; sw_rc_on = 1'b0;
        cycles(3);
        base = pulses; deep_sleep = 1'b1; cycles(40);
        check("R2 no pulse when disabled", pulses - base, 0);
        check("R2 no forced request", rc_req, 0);

        // R7: RC off at entry, forced on; code 1 -> 8 edges
        deep_sleep = 1'b0; cfg_enable = 1'b1; rc_ready = 1'b0; cfg_ps = 4'd1;
        cycles(3);
        base = pulses; deep_sleep = 1'b1; cycles(1);
        check("R7 RC forced on", rc_req, 1);
        rc_ready = 1'b1; cycles(25);
        check("R5 pulse code1", pulses - base, 1);
        deep_sleep = 1'b0; cycles(1);
        check("R7 request released on exit", rc_req, 0);

        cycles(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule